// File: doc/BRIEF.md
# Lockable Per-Instance State Readout Gate

This block gives software a single 32-bit data window for reading the internal state words of three generator instances. Software picks an instance through a select register. That write restarts the word sequence for the instance and emits a one-cycle restart pulse toward the state source. Each granted read of the window returns the current word and steps the word index on to the next one.

A read returns real data only when three separate qualifications agree:

- a 4-bit global software read switch,
- an 8-bit fuse-derived enable,
- a per-instance enable bit held inside the block.

All three per-instance bits start as readable. Software can drop them one at a time, for example after finishing known-answer tests on an instance. A clear-only lock bit then freezes the bits until the next reset. When any qualification fails, the window reads as zero and the sequence does not move.

The register bus is a simple single-cycle interface. Writes take effect at the clock edge. Read data is combinational in the cycle where `reg_re_i` is high. The gate is evaluated at the moment of each read.

Top module: `state_readout_gate`

## Requirements
- R1: After reset the per-instance enable field is 3'b111, the lock bit is 1 and the select register is 0.
- R2: The lock register at 0x3C reads its value in bit 0. A write with byte enable bit 0 set and write data bit 0 equal to 0 clears it. Writing 1 never sets it. It stays 0 until reset.
- R3: The enable field at 0x38 (bits [2:0], bit i for instance i) takes write data bits [2:0] only when byte enable bit 0 is set and the lock bit is 1. Otherwise the write is ignored.
- R4: Reads of 0x38, 0x3C and 0x40 return the enable field, the lock bit and the 4-bit select value, zero-extended. Unmapped addresses, and any cycle without `reg_re_i`, read as zero.
- R5: A read of the window at 0x44 returns `src_word_i` only when `glb_rd_en_i` is 4'h6, `fuse_en_i` is 8'h96, the select value is below 3, and the enable bit of the selected instance is 1.
- R6: If any condition of R5 fails, the window reads as zero and the word index does not change.
- R7: A write to 0x40 with byte enable bit 0 set loads write data bits [3:0] as the instance select and resets the word index to 0. In the following cycle `src_restart_o` is high for exactly one cycle.
- R8: Each granted window read advances `src_idx_o` by one, wrapping from NumWords-1 to 0. `src_inst_o` always shows the select value.
- R9: A select value of 3 or above makes the window read zero and never advances the index.
- R10: Clearing an enable bit takes effect on the very next window read, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 7 | Byte address |
| reg_be_i | input | 4 | Byte enables |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| glb_rd_en_i | input | 4 | Global read switch, 4'h6 means enabled |
| fuse_en_i | input | 8 | Fuse-derived enable, 8'h96 means enabled |
| src_inst_o | output | 4 | Selected instance toward the state source |
| src_idx_o | output | 3 | Current word index toward the state source |
| src_restart_o | output | 1 | One-cycle pulse after a select write |
| src_word_i | input | 32 | State word for the current instance and index |

## Verification
The bench runs a full sweep over the three qualifications: global switch values 6, 9 and 0; fuse values 96, 69 and 00; all eight enable-field patterns; and each instance. This separates a gate that ignores one condition, or indexes the wrong enable bit, from a correct one.

Long runs of reads on one instance show whether the index wraps and whether it advances only on granted reads. Out-of-range selects (3 and 15) show the zero-and-hold behaviour.

Lock sequences cover several cases:
- writes of 1 to the lock,
- writes without byte lane 0,
- enable writes after the lock is cleared,
- a second reset.

Together they show whether the enable field can be reopened.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
  localparam logic [3:0] SW_ON   = 4'h6;
  localparam logic [7:0] FUSE_ON = 8'h96;

  localparam logic [6:0] OFF_EN   = 7'h38;
  localparam logic [6:0] OFF_LOCK = 7'h3C;
  localparam logic [6:0] OFF_SEL  = 7'h40;
  localparam logic [6:0] OFF_VAL  = 7'h44;

  // Global part of the gate: both multi-bit switches must carry the true code.
  function automatic logic global_open(logic [3:0] sw, logic [7:0] fuse);
    return (sw == SW_ON) && (fuse == FUSE_ON);
  endfunction
endpackage

// File: rtl/sgate_cfg_regs.sv
module sgate_cfg_regs
  import sgate_pkg::*;
#(
  parameter int NumInst = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [6:0]         addr_i,
  input  logic               be0_i,
  input  logic [NumInst-1:0] wdata_i,
  output logic [NumInst-1:0] en_o,
  output logic               lock_o
);
  logic [NumInst-1:0] en_q;
  logic               lock_q;
  logic               en_wr;
  logic               lock_clr;

  assign en_wr    = we_i && be0_i && (addr_i == OFF_EN) && lock_q;
  assign lock_clr = we_i && be0_i && (addr_i == OFF_LOCK) && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '1;
      lock_q <= 1'b1;
    end else begin
      if (lock_clr) lock_q <= 1'b0;
      if (en_wr)    en_q   <= wdata_i;
    end
  end

  assign en_o   = en_q;
  assign lock_o = lock_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q); // R2
  AST_EN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> $stable(en_q)); // R3
endmodule

// File: rtl/sgate_word_seq.sv
module sgate_word_seq
  import sgate_pkg::*;
#(
  parameter int NumInst  = 3,
  parameter int NumWords = 6,
  parameter int SelW     = 4,
  localparam int IdxW    = $clog2(NumWords)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [6:0]      addr_i,
  input  logic            be0_i,
  input  logic [SelW-1:0] wdata_i,
  input  logic            advance_i,
  output logic [SelW-1:0] sel_o,
  output logic [IdxW-1:0] idx_o,
  output logic            restart_o
);
  logic [SelW-1:0] sel_q;
  logic [IdxW-1:0] idx_q;
  logic            restart_q;
  logic            sel_wr;

  assign sel_wr = we_i && be0_i && (addr_i == OFF_SEL);

  function automatic logic [IdxW-1:0] next_idx(logic [IdxW-1:0] i);
    return (i == IdxW'(NumWords - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      idx_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= sel_wr;
      if (sel_wr) begin
        sel_q <= wdata_i;
        idx_q <= '0;
      end else if (advance_i) begin
        idx_q <= next_idx(idx_q);
      end
    end
  end

  assign sel_o     = sel_q;
  assign idx_o     = idx_q;
  assign restart_o = restart_q;

  AST_RESTART_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |-> (idx_q == '0)); // R7
  AST_BAD_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == OFF_VAL && sel_q >= SelW'(NumInst) && !sel_wr) |=> $stable(idx_q)); // R9
endmodule

// File: rtl/state_readout_gate.sv
module state_readout_gate
  import sgate_pkg::*;
#(
  parameter int NumInst  = 3,
  parameter int NumWords = 6,
  parameter int SelW     = 4,
  localparam int IdxW    = $clog2(NumWords)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  input  logic [6:0]      reg_addr_i,
  input  logic [3:0]      reg_be_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic [3:0]      glb_rd_en_i,
  input  logic [7:0]      fuse_en_i,
  output logic [SelW-1:0] src_inst_o,
  output logic [IdxW-1:0] src_idx_o,
  output logic            src_restart_o,
  input  logic [31:0]     src_word_i
);
  logic [NumInst-1:0] en;
  logic               lock;
  logic [SelW-1:0]    sel;
  logic [IdxW-1:0]    idx;
  logic               sel_valid;
  logic               inst_en;
  logic               grant;
  logic               val_rd;
  logic               unused_bits;

  assign unused_bits = ^{reg_wdata_i[31:SelW], reg_be_i[3:1]};

  sgate_cfg_regs #(.NumInst(NumInst)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .be0_i   (reg_be_i[0]),
    .wdata_i (reg_wdata_i[NumInst-1:0]),
    .en_o    (en),
    .lock_o  (lock)
  );

  // Gate evaluated combinationally at the read itself.
  assign sel_valid = sel < SelW'(NumInst);
  assign inst_en   = |(en & (NumInst'(1) << sel));
  assign grant     = global_open(glb_rd_en_i, fuse_en_i) && sel_valid && inst_en;
  assign val_rd    = reg_re_i && (reg_addr_i == OFF_VAL);

  sgate_word_seq #(.NumInst(NumInst), .NumWords(NumWords), .SelW(SelW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .re_i      (reg_re_i),
    .addr_i    (reg_addr_i),
    .be0_i     (reg_be_i[0]),
    .wdata_i   (reg_wdata_i[SelW-1:0]),
    .advance_i (val_rd && grant),
    .sel_o     (sel),
    .idx_o     (idx),
    .restart_o (src_restart_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_re_i) begin
      unique case (reg_addr_i)
        OFF_EN:   reg_rdata_o = 32'(en);
        OFF_LOCK: reg_rdata_o = 32'(lock);
        OFF_SEL:  reg_rdata_o = 32'(sel);
        OFF_VAL:  reg_rdata_o = grant ? src_word_i : '0;
        default:  reg_rdata_o = '0;
      endcase
    end
  end

  assign src_inst_o = sel;
  assign src_idx_o  = idx;

  AST_CLOSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_rd && !global_open(glb_rd_en_i, fuse_en_i)) |-> (reg_rdata_o == '0)); // R6
  AST_LOCKED_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_restart_o |=> !src_restart_o || $past(reg_we_i)); // R7
endmodule

// File: tb/tb_state_readout_gate.sv
`timescale 1ns/1ps
module tb_state_readout_gate;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [6:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  glb = 4'h9;
  logic [7:0]  fuse = 8'h69;
  logic [3:0]  s_inst;
  logic [2:0]  s_idx;
  logic        s_rst;
  logic [31:0] s_word;

  int checks = 0, errors = 0;
  int m_en, m_lock, m_sel, m_idx;
  bit run = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] src_fn(int inst, int idx);
    return 32'h5EED_0000 ^ (inst << 12) ^ (idx * 32'h0000_0111);
  endfunction

  assign s_word = src_fn(int'(s_inst), int'(s_idx));

  state_readout_gate dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_be_i(be), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .glb_rd_en_i(glb), .fuse_en_i(fuse), .src_inst_o(s_inst), .src_idx_o(s_idx),
    .src_restart_o(s_rst), .src_word_i(s_word)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 7; m_lock = 1; m_sel = 0; m_idx = 0;
  endtask

  task automatic do_reset();
    run = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; model_reset();
    run = 1'b1;
  endtask

  task automatic wr(logic [6:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; be = b; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; be = '0;
    if (b[0]) begin
      if (a == 7'h38 && m_lock == 1) m_en = int'(d[2:0]);
      if (a == 7'h3C && !d[0]) m_lock = 0;
      if (a == 7'h40) begin m_sel = int'(d[3:0]); m_idx = 0; end
    end
    if (b[0] && a == 7'h40) begin
      chk("R7 restart high", 32'(s_rst), 1);
      @(posedge clk); #1;
      chk("R7 restart one cycle", 32'(s_rst), 0);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [6:0] a);
    bit open;
    open = (glb == 4'h6) && (fuse == 8'h96) && (m_sel < 3) && ((m_en >> m_sel) & 1) == 1;
    case (a)
      7'h38: return 32'(m_en);
      7'h3C: return 32'(m_lock);
      7'h40: return 32'(m_sel);
      7'h44: return open ? src_fn(m_sel, m_idx) : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd(logic [6:0] a, string req);
    logic [31:0] e;
    bit open;
    @(negedge clk);
    re = 1'b1; addr = a;
    #1;
    e = exp_rd(a);
    open = (a == 7'h44) && (e != 0);
    chk(req, rdata, e);
    @(posedge clk); #1;
    re = 1'b0;
    if (open) m_idx = (m_idx + 1) % NW;
  endtask

  // Per-clock comparison of the source-facing outputs against the model (R8).
  always @(negedge clk) begin
    if (run && rst_n) begin
      chk("R8 idx", 32'(s_idx), 32'(m_idx));
      chk("R8 inst", 32'(s_inst), 32'(m_sel));
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1; run = 1'b1;
    // R1, R4: reset values and register map
    rd(7'h38, "R1 en reset");
    rd(7'h3C, "R1 lock reset");
    rd(7'h40, "R1 sel reset");
    rd(7'h10, "R4 unmapped");
    chk("R4 no read strobe", rdata, 0);
    // R6: closed by default switches
    rd(7'h44, "R6 closed global");
    // R5, R8: open and walk past wrap
    glb = 4'h6; fuse = 8'h96;
    for (int i = 0; i < 2 * NW + 1; i++) rd(7'h44, "R8 walk inst0");
    wr(7'h40, 4'h1, 32'h1);
    for (int i = 0; i < 3; i++) rd(7'h44, "R5 inst1");
    // R9: out-of-range selects
    wr(7'h40, 4'h1, 32'h3);
    rd(7'h44, "R9 sel3"); rd(7'h44, "R9 sel3 again");
    wr(7'h40, 4'h1, 32'hF);
    rd(7'h44, "R9 sel15"); rd(7'h40, "R4 sel readback");
    // R7: select write without byte lane 0 ignored
    wr(7'h40, 4'h1, 32'h2);
    rd(7'h44, "R5 inst2");
    wr(7'h40, 4'hE, 32'h0);
    rd(7'h40, "R7 be ignored");
    // R10: clear enable then read immediately
    wr(7'h38, 4'h1, 32'h3);
    rd(7'h44, "R10 cleared bit");
    wr(7'h38, 4'h1, 32'h7);
    // R5, R6: full sweep of qualifications
    for (int g = 0; g < 3; g++) begin
      for (int f = 0; f < 3; f++) begin
        glb  = (g == 0) ? 4'h6 : (g == 1) ? 4'h9 : 4'h0;
        fuse = (f == 0) ? 8'h96 : (f == 1) ? 8'h69 : 8'h00;
        for (int e = 0; e < 8; e++) begin
          wr(7'h38, 4'h1, 32'(e));
          for (int n = 0; n < 3; n++) begin
            wr(7'h40, 4'h1, 32'(n));
            rd(7'h44, "R5 sweep");
            rd(7'h44, "R6 sweep");
          end
        end
      end
    end
    glb = 4'h6; fuse = 8'h96;
    // R3: byte lane 0 required
    wr(7'h38, 4'h1, 32'h5);
    wr(7'h38, 4'hE, 32'h2);
    rd(7'h38, "R3 be ignored");
    // R2: lock behaviour
    wr(7'h3C, 4'h1, 32'h1);
    rd(7'h3C, "R2 write1 no effect");
    wr(7'h3C, 4'hE, 32'h0);
    rd(7'h3C, "R2 be ignored");
    wr(7'h3C, 4'h1, 32'h0);
    rd(7'h3C, "R2 cleared");
    wr(7'h3C, 4'h1, 32'h1);
    rd(7'h3C, "R2 cannot reopen");
    wr(7'h38, 4'h1, 32'h7);
    rd(7'h38, "R3 locked write ignored");
    wr(7'h40, 4'h1, 32'h1);
    rd(7'h44, "R3 locked inst1 still off");
    wr(7'h40, 4'h1, 32'h0);
    rd(7'h44, "R5 locked inst0 on");
    // R2: reset reopens
    do_reset();
    rd(7'h3C, "R2 lock after reset");
    rd(7'h38, "R1 en after reset");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule